// File: doc/BRIEF.md
# Chained Pixel Receiver and Repeater

This block is the digital core of one pixel in a daisy chain of addressable colour LEDs. A single wire carries a frame of bits. Each bit is a high pulse followed by a low phase, and the bit's value is given only by how long the line stays high. The block samples the wire with its own system clock after a two-flop synchroniser. It keeps the first 24 bits of a frame for itself and regenerates every later bit on its output with clean, nominal timing, so the next pixel in the chain receives a well-formed stream.

The colour arrives as three bytes, most significant bit first, in the order green, red, blue. It is presented on separate red, green and blue outputs. The outputs are updated only when the line has been low long enough to end the frame. At that moment `col_vld` pulses for one cycle. This pulse is a valid strobe with no ready: the serial line cannot be stalled, so there is no back-pressure on either side. A consumer must take the colour whenever `col_vld` is high, and the colour stays on the outputs until the next complete frame ends.

All timings are counted in clock ticks derived from `CLK_HZ`. For each quantity, the number of clock cycles per microsecond (`CLK_HZ`/1e6, rounded down) is multiplied by the duration in nanoseconds and divided by 1000, rounded down. The quantities are:
- the 1/0 decision threshold of 625 ns;
- the frame-end low time of 50 µs;
- a regenerated 0: 400 ns high, 850 ns low;
- a regenerated 1: 800 ns high, 450 ns low.

Top module: `pxl_relay`

## Requirements
- R1: After reset, `red`, `green` and `blue` are 0, `dout` is low and `col_vld` is low.
- R2: A received bit is 1 when its synchronised high phase lasts at least the threshold tick count, and 0 when it is shorter. One tick below the threshold decodes as 0; exactly the threshold decodes as 1.
- R3: The first 24 bits of a frame are taken MSB first as three bytes. The first byte goes to `green`, the second to `red` and the third to `blue`.
- R4: The colour outputs change only once the line has been low for the frame-end tick count. While bits are still arriving, and during a low stretch shorter than that, they hold their previous value.
- R5: A frame that ends with fewer than 24 bits leaves the colour outputs unchanged and raises no `col_vld`.
- R6: Each bit after the 24th is re-emitted on `dout`. A 0 is high for the 0-high tick count and a 1 is high for the 1-high tick count. Each is then low for its own low tick count.
- R7: A forwarded bit that arrives while an earlier one is still being emitted is held in a one-bit queue. It is emitted right after the earlier bit's low phase, keeping the arrival order.
- R8: The end of a frame re-arms the block. The next frame's first 24 bits are captured again and produce no pulse on `dout`.
- R9: `col_vld` is a single-cycle pulse, raised once per completed frame together with the new colour.
- R10: A low stretch shorter than the frame-end time in the middle of a frame does not split the frame. Bits before and after it count toward the same 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial input from the previous pixel (asynchronous) |
| dout | output | 1 | Regenerated serial output to the next pixel |
| red | output | CH_W | Latched red byte |
| green | output | CH_W | Latched green byte |
| blue | output | CH_W | Latched blue byte |
| col_vld | output | 1 | One-cycle strobe when a new colour is latched |

## Verification
Counted from the clock edge after the bench pulls `din` low, the new colour and `col_vld` appear about frame-end-ticks + 3 cycles later. The delay comes from two synchroniser flops, the low-run counter, the registered frame-end flag and the colour register. The bench therefore checks that the colour has not changed 40 cycles before that point, and checks for the new value well after it. Forwarded bits reach `dout` with a few cycles of pipeline delay. Because of that, `dout` is judged by a monitor that measures the length of each high run, and of the low run before each pulse, rather than by fixed sample points. The decision threshold is tested at exactly one tick below it and exactly at it.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  // nominal durations in nanoseconds
  localparam int THR_NS = 625;
  localparam int EOF_NS = 50000;
  localparam int Z_HI_NS = 400;
  localparam int Z_LO_NS = 850;
  localparam int O_HI_NS = 800;
  localparam int O_LO_NS = 450;

  // whole clock ticks for a duration; stays within 32 bits for any usable clock
  function automatic int ns2tick(input int hz, input int ns);
    return (hz / 1_000_000) * ns / 1000;
  endfunction

  typedef enum logic [1:0] {EM_IDLE, EM_HIGH, EM_LOW} em_state_t;
endpackage

// File: rtl/pxl_rx.sv
// Synchronises the line, measures high and low runs, classifies bits, flags frame end.
module pxl_rx #(
  parameter int THR = 10,
  parameter int EOF = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic bit_vld,
  output logic bit_val,
  output logic frm_end
);
  localparam int HW = $clog2(THR + 1);
  localparam int LW = $clog2(EOF + 1);

  logic s1, s2, s_prev;
  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s_prev <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
      frm_end <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s_prev <= s2;
      if (s2) hi_cnt <= (hi_cnt == HW'(THR)) ? hi_cnt : hi_cnt + 1'b1;
      else    hi_cnt <= '0;
      if (s2) lo_cnt <= '0;
      else    lo_cnt <= (lo_cnt == LW'(EOF)) ? lo_cnt : lo_cnt + 1'b1;
      bit_vld <= !s2 && s_prev;
      bit_val <= (hi_cnt >= HW'(THR));
      frm_end <= !s2 && (lo_cnt == LW'(EOF - 1));
    end
  end
endmodule

// File: rtl/pxl_cap.sv
// Keeps the first 3*CH_W bits of a frame, passes the rest on, latches colour at frame end.
module pxl_cap #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_vld,
  input  logic            bit_val,
  input  logic            frm_end,
  output logic            fwd_vld,
  output logic            fwd_bit,
  output logic [CH_W-1:0] red,
  output logic [CH_W-1:0] green,
  output logic [CH_W-1:0] blue,
  output logic            col_vld
);
  localparam int PIX_BITS = 3 * CH_W;
  localparam int CW = $clog2(PIX_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(PIX_BITS);

  logic [CW-1:0] cnt;
  logic [PIX_BITS-1:0] sh;
  logic latch_en;

  assign latch_en = frm_end && (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh <= '0;
      fwd_vld <= 1'b0;
      fwd_bit <= 1'b0;
      col_vld <= 1'b0;
    end else begin
      fwd_vld <= 1'b0;
      col_vld <= latch_en;
      if (frm_end) begin
        cnt <= '0;
      end else if (bit_vld) begin
        if (cnt < FULL) begin
          sh <= {sh[PIX_BITS-2:0], bit_val};
          cnt <= cnt + 1'b1;
        end else begin
          fwd_vld <= 1'b1;
          fwd_bit <= bit_val;
        end
      end
    end
  end

  // arrival slot 0 = green, 1 = red, 2 = blue
  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CH_W-1:0] ch_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q <= '0;
      else if (latch_en) ch_q <= sh[PIX_BITS-1-c*CH_W -: CH_W];
    end
  end

  assign green = g_ch[0].ch_q;
  assign red   = g_ch[1].ch_q;
  assign blue  = g_ch[2].ch_q;
endmodule

// File: rtl/pxl_regen.sv
// Re-emits forwarded bits with nominal timing, one bit of queue.
module pxl_regen
  import pxl_pkg::*;
#(
  parameter int Z_HI = 6,
  parameter int Z_LO = 13,
  parameter int O_HI = 12,
  parameter int O_LO = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_vld,
  input  logic fwd_bit,
  output logic dout
);
  localparam int MAX_A = (Z_HI > Z_LO) ? Z_HI : Z_LO;
  localparam int MAX_B = (O_HI > O_LO) ? O_HI : O_LO;
  localparam int TMAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW = $clog2(TMAX + 1);

  em_state_t st;
  logic [CW-1:0] cnt;
  logic cur, q_full, q_bit;

  function automatic logic [CW-1:0] hi_len(input logic b);
    return b ? CW'(O_HI - 1) : CW'(Z_HI - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= EM_IDLE;
      cnt <= '0;
      cur <= 1'b0;
      q_full <= 1'b0;
      q_bit <= 1'b0;
      dout <= 1'b0;
    end else begin
      unique case (st)
        EM_IDLE: begin
          if (fwd_vld) begin
            st <= EM_HIGH;
            dout <= 1'b1;
            cur <= fwd_bit;
            cnt <= hi_len(fwd_bit);
          end
        end
        EM_HIGH: begin
          if (cnt == '0) begin
            st <= EM_LOW;
            dout <= 1'b0;
            cnt <= cur ? CW'(O_LO - 1) : CW'(Z_LO - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
          if (fwd_vld && !q_full) begin
            q_full <= 1'b1;
            q_bit <= fwd_bit;
          end
        end
        default: begin
          if (cnt == '0) begin
            if (q_full) begin
              st <= EM_HIGH;
              dout <= 1'b1;
              cur <= q_bit;
              cnt <= hi_len(q_bit);
              q_full <= fwd_vld;
              if (fwd_vld) q_bit <= fwd_bit;
            end else if (fwd_vld) begin
              st <= EM_HIGH;
              dout <= 1'b1;
              cur <= fwd_bit;
              cnt <= hi_len(fwd_bit);
            end else begin
              st <= EM_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
            if (fwd_vld && !q_full) begin
              q_full <= 1'b1;
              q_bit <= fwd_bit;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pxl_relay.sv
module pxl_relay
  import pxl_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  output logic            dout,
  output logic [CH_W-1:0] red,
  output logic [CH_W-1:0] green,
  output logic [CH_W-1:0] blue,
  output logic            col_vld
);
  localparam int THR_T  = ns2tick(CLK_HZ, THR_NS);
  localparam int EOF_T  = ns2tick(CLK_HZ, EOF_NS);
  localparam int Z_HI_T = ns2tick(CLK_HZ, Z_HI_NS);
  localparam int Z_LO_T = ns2tick(CLK_HZ, Z_LO_NS);
  localparam int O_HI_T = ns2tick(CLK_HZ, O_HI_NS);
  localparam int O_LO_T = ns2tick(CLK_HZ, O_LO_NS);

  logic bit_vld, bit_val, frm_end, fwd_vld, fwd_bit;

  pxl_rx #(.THR(THR_T), .EOF(EOF_T)) u_rx (
    .clk(clk), .rst_n(rst_n), .din(din),
    .bit_vld(bit_vld), .bit_val(bit_val), .frm_end(frm_end)
  );

  pxl_cap #(.CH_W(CH_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .bit_vld(bit_vld), .bit_val(bit_val), .frm_end(frm_end),
    .fwd_vld(fwd_vld), .fwd_bit(fwd_bit),
    .red(red), .green(green), .blue(blue), .col_vld(col_vld)
  );

  pxl_regen #(.Z_HI(Z_HI_T), .Z_LO(Z_LO_T), .O_HI(O_HI_T), .O_LO(O_LO_T)) u_regen (
    .clk(clk), .rst_n(rst_n), .fwd_vld(fwd_vld), .fwd_bit(fwd_bit), .dout(dout)
  );
endmodule

// File: rtl/pxl_relay_chk.sv
module pxl_relay_chk
  import pxl_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int CH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            din,
  input logic            dout,
  input logic [CH_W-1:0] red,
  input logic [CH_W-1:0] green,
  input logic [CH_W-1:0] blue,
  input logic            col_vld
);
  localparam int EOF_T  = ns2tick(CLK_HZ, EOF_NS);
  localparam int O_HI_T = ns2tick(CLK_HZ, O_HI_NS);

  int unsigned lo_run;
  int unsigned hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= 0;
      hi_run <= 0;
    end else begin
      lo_run <= din ? 0 : ((lo_run >= EOF_T) ? lo_run : lo_run + 1);
      hi_run <= dout ? hi_run + 1 : 0;
    end
  end

  // R9
  col_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld |=> !col_vld);

  // R4
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_vld |-> $stable({red, green, blue}));

  // R10
  col_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld |-> (lo_run >= EOF_T));

  // R6
  dout_hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout |-> (hi_run < O_HI_T));
endmodule

bind pxl_relay pxl_relay_chk #(.CLK_HZ(CLK_HZ), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .dout(dout),
  .red(red), .green(green), .blue(blue), .col_vld(col_vld)
);

// File: tb/tb_pxl_relay.sv
`timescale 1ns/1ps
module tb_pxl_relay;
  localparam int HZ = 16_000_000;
  localparam int TPU = HZ / 1_000_000;
  localparam int THR = TPU * 625 / 1000;    // 10
  localparam int EOF = TPU * 50000 / 1000;  // 800
  localparam int ZH = TPU * 400 / 1000;     // 6
  localparam int OH = TPU * 800 / 1000;     // 12
  localparam int OL = TPU * 450 / 1000;     // 7

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic dout, col_vld;
  logic [7:0] red, green, blue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pxl_relay #(.CLK_HZ(HZ), .CH_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .dout(dout),
    .red(red), .green(green), .blue(blue), .col_vld(col_vld)
  );

  // output monitor: high-run width of each pulse and the low run before it
  int hw [64];
  int lw [64];
  int np = 0;
  int hrun = 0;
  int lrun = 0;
  int nvld = 0;
  logic dprev = 1'b0;

  always @(negedge clk) begin
    if (col_vld) nvld <= nvld + 1;
    if (dout) begin
      if (!dprev && np < 64) lw[np] <= lrun;
      hrun <= hrun + 1;
      lrun <= 0;
    end else begin
      if (dprev && np < 64) begin
        hw[np] <= hrun;
        np <= np + 1;
      end
      hrun <= 0;
      lrun <= lrun + 1;
    end
    dprev <= dout;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_col(input string req, input logic [23:0] grb);
    chk({red, green, blue} == {grb[15:8], grb[23:16], grb[7:0]}, req,
        {red, green, blue}, {grb[15:8], grb[23:16], grb[7:0]});
  endtask

  task automatic send_bit(input bit b, input int hi, input int lo);
    din = 1'b1;
    repeat (hi) @(negedge clk);
    din = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  // n bits of w, MSB first, with given high widths and a 20-tick period
  task automatic send_bits(input logic [23:0] w, input int n, input int h0, input int h1);
    for (int i = n - 1; i >= 0; i--)
      send_bit(w[i], w[i] ? h1 : h0, 20 - (w[i] ? h1 : h0));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base, v0;
    @(negedge clk);
    idle(4);
    // R1 reset state
    chk(dout == 1'b0 && col_vld == 1'b0, "R1 dout/col_vld", {dout, col_vld}, 0);
    chk({red, green, blue} == 24'h0, "R1 colour", {red, green, blue}, 0);
    rst_n = 1'b1;
    idle(EOF + 20);

    // R3/R4/R9: standard frame
    v0 = nvld;
    send_bits(24'h123456, 24, ZH, OH);
    idle(EOF - 40);
    chk_col("R4 hold before frame end", 24'h000000);
    idle(80);
    chk_col("R3 GRB remap", 24'h123456);
    chk(nvld == v0 + 1, "R9 one col_vld", nvld - v0, 1);

    // R2: threshold boundary, 0s one tick short, 1s exactly at threshold
    send_bits(24'hA5C30F, 24, THR - 1, THR);
    idle(EOF + 40);
    chk_col("R2 threshold", 24'hA5C30F);

    // R5: short frame ignored
    v0 = nvld;
    send_bits(24'hFFFFFF, 10, ZH, OH);
    idle(EOF + 40);
    chk_col("R5 short frame keeps colour", 24'hA5C30F);
    chk(nvld == v0, "R5 no col_vld", nvld - v0, 0);

    // R10: sub-frame-end low stretch in mid frame
    send_bits(24'h3C5A00 >> 12, 12, ZH, OH);
    idle(EOF - 100);
    send_bits(24'h000A81, 12, ZH, OH);
    idle(EOF + 40);
    chk_col("R10 gap does not split", {12'h3C5, 12'hA81});

    // R6/R8: four bits beyond 24 forwarded with nominal high widths
    base = np;
    send_bits(24'h00FF00, 24, ZH, OH);
    chk(np == base, "R8 own bits not forwarded", np - base, 0);
    send_bits(24'hB, 4, ZH, OH);
    idle(EOF + 40);
    chk(np == base + 4, "R6 forwarded pulse count", np - base, 4);
    chk(hw[base] == OH && hw[base+1] == ZH && hw[base+2] == OH && hw[base+3] == OH,
        "R6 pulse widths", {hw[base][7:0], hw[base+1][7:0], hw[base+2][7:0], hw[base+3][7:0]},
        {OH[7:0], ZH[7:0], OH[7:0], OH[7:0]});
    chk_col("R3 colour with forwarded tail", 24'h00FF00);

    // R8: next frame re-armed, captured, nothing forwarded
    base = np;
    send_bits(24'h0000FF, 24, ZH, OH);
    idle(EOF + 40);
    chk(np == base, "R8 re-armed no forward", np - base, 0);
    chk_col("R8 new frame captured", 24'h0000FF);

    // R7: second forwarded bit arrives while first is still emitted
    base = np;
    send_bits(24'h777777, 24, ZH, OH);
    send_bit(1'b1, OH, 3);
    send_bit(1'b0, ZH, 14);
    idle(EOF + 40);
    chk(np == base + 2, "R7 queued count", np - base, 2);
    chk(hw[base] == OH && hw[base+1] == ZH, "R7 order", {hw[base][7:0], hw[base+1][7:0]},
        {OH[7:0], ZH[7:0]});
    chk(lw[base+1] == OL, "R7 back-to-back gap", lw[base+1], OL);
    chk_col("R7 colour", 24'h777777);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule